// File: doc/BRIEF.md
# Priority Interrupt Arbiter with Protected-Write Hold-off

This block decides when a small single-issue CPU should leave its instruction stream to service a request, and which request it should service. Each request line is either latched, where a one-cycle event sets a sticky flag, or level-sensitive, where the line itself is the request. Each line has its own enable. A global enable sits above all of them. The CPU reports instruction boundaries, sleep, and the completion of return-from-interrupt, set-enable and clear-enable instructions. It also reports writes to a protected-write unlock register.

On acceptance, the arbiter pulses `take_o`, publishes the winning index on `vec_o`, strobes the clear for that index's flag and drops the global enable. A response counter then models the delay before the vector is fetched, and `vec_fetch_o` marks that moment. The datapath, the stack and the vector fetch sit outside the block. A correct signature written to the unlock register opens a short window in which no request is accepted.

Top module: `irq_arbiter`

## Requirements
- R1: Among pending requests whose own enable is set, the lowest index wins. Acceptance happens only while the global enable is on. `vec_o` carries the winner's index as a binary number.
- R2: Acceptance clears `gie_o` on the same clock edge that raises `take_o`. A completed return-from-interrupt or set-enable sets `gie_o`.
- R3: A flag-type line sets its flag even while its own enable or the global enable is off. The flag stays pending and is taken once both enables are on.
- R4: Taking a flag-type index clears that flag and raises bit `vec_o` of `flag_clr_o` in the `take_o` cycle. `flag_clr_o` is zero when the winner is level-type. A one on `flag_wclr_i[i]` clears flag i, and the request is then never taken.
- R5: A level-type line (default: index 3) has no memory. If it drops before the enables are on, it is never taken.
- R6: After a boundary that completes a return-from-interrupt or set-enable, the next boundary cannot accept. The boundary after that can.
- R7: Clear-enable blocks acceptance in its own cycle, even for a request present in that cycle, and `gie_o` reads 0 afterwards.
- R8: Counting the `take_o` cycle as cycle 1, `vec_fetch_o` pulses in cycle 4. It pulses in cycle 8 when `sleep_i` was high at acceptance. While `sleep_i` is high, acceptance needs no boundary, and no new acceptance happens before the fetch.
- R9: After a write of the signature (default 0xA5), the next four instruction boundaries cannot accept. The fifth can.
- R10: `unlock_rd_o` reads 0x01 while the window is open and 0x00 otherwise.
- R11: A write of any other value neither opens the window nor changes an open one. Rewriting the signature while the window is open restarts the count at four.
- R12: `take_o` lasts exactly one cycle and follows a boundary (or sleep). `vec_o` holds its value until the next acceptance.
- R13: While reset is asserted and just after it, `take_o`, `gie_o`, `vec_fetch_o`, `flag_clr_o` and `unlock_rd_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | N | Event pulse (flag type) or level condition per line |
| src_en_i | input | N | Per-line enable |
| flag_wclr_i | input | N | Write-one-to-clear for latched flags |
| insn_bnd_i | input | 1 | An instruction completes this cycle |
| reti_i | input | 1 | The completing instruction is return-from-interrupt |
| sei_i | input | 1 | The completing instruction sets the global enable |
| cli_i | input | 1 | The completing instruction clears the global enable |
| sleep_i | input | 1 | Core is sleeping |
| unlock_wr_i | input | 1 | Write strobe to the unlock register |
| unlock_data_i | input | 8 | Write data for the unlock register |
| take_o | output | 1 | One-cycle acceptance pulse |
| vec_o | output | clog2(N) | Index of the last accepted line |
| flag_clr_o | output | N | One-hot hardware flag clear on acceptance |
| vec_fetch_o | output | 1 | End of the modelled response time |
| gie_o | output | 1 | Global enable state |
| unlock_rd_o | output | 8 | Readable value of the unlock register |

## Verification
Every non-empty combination of four pending lines, three latched and one level, is presented. The expected index is computed as the lowest set bit. This separates a correct priority encoder from one that favours the top index or ignores the level line. Further sequences place latching, software clear, and level loss around the enable changes, so a design that latches level lines, or forgets latched ones, gets a different answer. Boundary counts after return, set-enable, clear-enable and signature writes pin each hold-off to its exact instruction, including a signature rewrite mid-window. Response lengths are measured awake and from sleep.

// File: rtl/irq_arbiter.sv
`timescale 1ns/1ps
module irq_arbiter #(
  parameter int N = 4,
  parameter logic [N-1:0] LEVEL_MASK = 4'b1000,
  parameter logic [7:0] SIG = 8'hA5,
  parameter int RESP_CYC = 4,
  parameter int WAKE_CYC = 4,
  parameter int WIN_LEN = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         req_i,
  input  logic [N-1:0]         src_en_i,
  input  logic [N-1:0]         flag_wclr_i,
  input  logic                 insn_bnd_i,
  input  logic                 reti_i,
  input  logic                 sei_i,
  input  logic                 cli_i,
  input  logic                 sleep_i,
  input  logic                 unlock_wr_i,
  input  logic [7:0]           unlock_data_i,
  output logic                 take_o,
  output logic [$clog2(N)-1:0] vec_o,
  output logic [N-1:0]         flag_clr_o,
  output logic                 vec_fetch_o,
  output logic                 gie_o,
  output logic [7:0]           unlock_rd_o
);
  localparam int VW = $clog2(N);
  localparam int CW = $clog2(RESP_CYC + WAKE_CYC + 1);
  localparam int WW = $clog2(WIN_LEN + 1);

  logic [N-1:0]  flag_q, pend, elig, take_hot;
  logic          gie_q, hold_q, take_q, found, take_now, sig_wr;
  logic [VW-1:0] vec_q, win_vec;
  logic [CW-1:0] resp_q;
  logic [WW-1:0] win_q;
  logic [N-1:0]  clr_q;

  assign sig_wr = unlock_wr_i && (unlock_data_i == SIG);
  assign pend   = (flag_q & ~LEVEL_MASK) | (req_i & LEVEL_MASK);
  assign elig   = pend & src_en_i;

  always_comb begin
    found   = 1'b0;
    win_vec = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig[i]) begin
        found   = 1'b1;
        win_vec = VW'(i);
      end
    end
  end

  assign take_now = found && gie_q && !cli_i && !sei_i && !reti_i && !hold_q
                 && (win_q == '0) && !sig_wr && (resp_q == '0)
                 && (insn_bnd_i || sleep_i);
  assign take_hot = take_now ? ({{(N-1){1'b0}}, 1'b1} << win_vec) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= '0;
      gie_q  <= 1'b0;
      hold_q <= 1'b0;
      take_q <= 1'b0;
      vec_q  <= '0;
      clr_q  <= '0;
      resp_q <= '0;
      win_q  <= '0;
    end else begin
      flag_q <= ((flag_q & ~flag_wclr_i & ~take_hot) | req_i) & ~LEVEL_MASK;

      if (take_now || cli_i) gie_q <= 1'b0;
      else if (sei_i || reti_i) gie_q <= 1'b1;

      if (sei_i || reti_i) hold_q <= 1'b1;
      else if (insn_bnd_i) hold_q <= 1'b0;

      take_q <= take_now;
      clr_q  <= take_hot & ~LEVEL_MASK;
      if (take_now) vec_q <= win_vec;

      if (take_now) resp_q <= sleep_i ? CW'(RESP_CYC + WAKE_CYC) : CW'(RESP_CYC);
      else if (resp_q != '0) resp_q <= resp_q - CW'(1);

      if (sig_wr) win_q <= WW'(WIN_LEN);
      else if (insn_bnd_i && win_q != '0) win_q <= win_q - WW'(1);
    end
  end

  assign take_o      = take_q;
  assign vec_o       = vec_q;
  assign flag_clr_o  = clr_q;
  assign vec_fetch_o = (resp_q == CW'(1));
  assign gie_o       = gie_q;
  assign unlock_rd_o = {7'b0, win_q != '0};
endmodule

// File: rtl/irq_arbiter_sva.sv
`timescale 1ns/1ps
module irq_arbiter_sva #(
  parameter int N = 4,
  parameter logic [7:0] SIG = 8'hA5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reti_i,
  input logic                 sei_i,
  input logic                 cli_i,
  input logic                 unlock_wr_i,
  input logic [7:0]           unlock_data_i,
  input logic                 take_o,
  input logic [$clog2(N)-1:0] vec_o,
  input logic [N-1:0]         flag_clr_o,
  input logic                 vec_fetch_o,
  input logic                 gie_o,
  input logic                 win_open
);
  AST_TAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) take_o |=> !take_o); // R12
  AST_VEC_HELD: assert property (@(posedge clk) disable iff (!rst_n) !take_o |-> $stable(vec_o)); // R12
  AST_TAKE_DROPS_GIE: assert property (@(posedge clk) disable iff (!rst_n) take_o |-> !gie_o); // R2
  AST_RETI_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n) reti_i |=> !take_o); // R6
  AST_SEI_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n) sei_i |=> !take_o); // R6
  AST_CLI_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n) cli_i |=> !take_o); // R7
  AST_WINDOW_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n) take_o |-> !$past(win_open)); // R9
  AST_WINDOW_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(win_open) |-> $past(unlock_wr_i && unlock_data_i == SIG)); // R11
  AST_FETCH_NOT_TAKE: assert property (@(posedge clk) disable iff (!rst_n) vec_fetch_o |-> !take_o); // R8
  AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(flag_clr_o)); // R4
endmodule

bind irq_arbiter irq_arbiter_sva #(.N(N), .SIG(SIG)) u_sva (
  .clk(clk), .rst_n(rst_n), .reti_i(reti_i), .sei_i(sei_i), .cli_i(cli_i),
  .unlock_wr_i(unlock_wr_i), .unlock_data_i(unlock_data_i), .take_o(take_o),
  .vec_o(vec_o), .flag_clr_o(flag_clr_o), .vec_fetch_o(vec_fetch_o),
  .gie_o(gie_o), .win_open(unlock_rd_o[0])
);

// File: tb/tb_irq_arbiter.sv
`timescale 1ns/1ps
module tb_irq_arbiter;
  localparam logic [7:0] SIG = 8'hA5;
  logic clk = 0, rst_n = 0;
  logic [3:0] req_i = 0, src_en_i = 0, flag_wclr_i = 0;
  logic insn_bnd_i = 0, reti_i = 0, sei_i = 0, cli_i = 0, sleep_i = 0, unlock_wr_i = 0;
  logic [7:0] unlock_data_i = 0;
  logic take_o, vec_fetch_o, gie_o;
  logic [1:0] vec_o;
  logic [3:0] flag_clr_o;
  logic [7:0] unlock_rd_o;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  irq_arbiter dut (.*);

  always #10 clk = ~clk;

  task automatic step(); @(posedge clk); #1; endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic instr(input logic s, input logic r, input logic c);
    sei_i = s; reti_i = r; cli_i = c; insn_bnd_i = 1;
    step();
    sei_i = 0; reti_i = 0; cli_i = 0; insn_bnd_i = 0;
  endtask

  task automatic bnd(); instr(0, 0, 0); endtask

  task automatic pulse(input logic [3:0] v);
    req_i = v; step(); req_i = 0;
  endtask

  task automatic fetch_len(input string tag, input int exp);
    int k = 0;
    while (!vec_fetch_o && k < 20) begin step(); k++; end
    chk(tag, k + 1, exp);
    step();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    step(); step();
    chk("R13 take in reset", take_o, 0);
    chk("R13 gie in reset", gie_o, 0);
    rst_n = 1;
    step();
    chk("R13 take after reset", take_o, 0);
    chk("R13 gie after reset", gie_o, 0);
    chk("R13 unlock after reset", unlock_rd_o, 0);
    chk("R13 fetch after reset", vec_fetch_o, 0);
    chk("R13 clr after reset", flag_clr_o, 0);

    src_en_i = 4'hF;
    for (int p = 1; p < 16; p++) begin
      int low = 0;
      for (int b = 3; b >= 0; b--) if (p[b]) low = b;
      instr(1, 0, 0);
      chk("R2 sei sets gie", gie_o, 1);
      pulse(4'(p) & 4'b0111);
      req_i = {p[3], 3'b0};
      bnd();
      chk("R6 sei holdoff", take_o, 0);
      bnd();
      chk("R1 take", take_o, 1);
      chk("R1 winner", vec_o, low);
      chk("R4 hw clear", flag_clr_o, (low < 3) ? (1 << low) : 0);
      chk("R2 take clears gie", gie_o, 0);
      fetch_len("R8 awake response", 4);
      chk("R12 single pulse", take_o, 0);
      chk("R12 vec held", vec_o, low);
      flag_wclr_i = 4'hF; req_i = 0; step(); flag_wclr_i = 0;
    end

    src_en_i = 4'hF;
    pulse(4'b1000); step();
    instr(1, 0, 0); bnd(); bnd();
    chk("R5 level lost", take_o, 0);
    src_en_i = 4'b1101;
    pulse(4'b0010);
    bnd(); bnd();
    chk("R3 masked flag waits", take_o, 0);
    src_en_i = 4'hF;
    bnd();
    chk("R3 latched flag taken", take_o, 1);
    chk("R3 latched vec", vec_o, 1);
    fetch_len("R8 awake response", 4);

    pulse(4'b0100);
    flag_wclr_i = 4'b0100; step(); flag_wclr_i = 0;
    instr(1, 0, 0); bnd(); bnd();
    chk("R4 sw clear drops request", take_o, 0);

    pulse(4'b0001);
    bnd();
    chk("R1 take idx0", take_o, 1);
    chk("R1 idx0", vec_o, 0);
    fetch_len("R8 awake response", 4);
    pulse(4'b0010);
    instr(0, 1, 0);
    chk("R2 reti sets gie", gie_o, 1);
    chk("R6 reti cycle", take_o, 0);
    bnd();
    chk("R6 one instruction after reti", take_o, 0);
    bnd();
    chk("R6 taken after one instruction", take_o, 1);
    chk("R6 vec", vec_o, 1);
    fetch_len("R8 awake response", 4);

    instr(1, 0, 0); bnd();
    req_i = 4'b1000;
    instr(0, 0, 1);
    chk("R7 cli same cycle", take_o, 0);
    chk("R7 gie off", gie_o, 0);
    bnd();
    chk("R7 stays blocked", take_o, 0);
    req_i = 0;

    instr(1, 0, 0); bnd();
    sleep_i = 1;
    pulse(4'b0100);
    step();
    chk("R8 wake take", take_o, 1);
    chk("R8 wake vec", vec_o, 2);
    sleep_i = 0;
    fetch_len("R8 sleep response", 8);

    chk("R10 closed", unlock_rd_o, 0);
    unlock_wr_i = 1; unlock_data_i = 8'h5A; step(); unlock_wr_i = 0;
    chk("R11 wrong value", unlock_rd_o, 0);
    instr(1, 0, 0); bnd();
    unlock_wr_i = 1; unlock_data_i = SIG; step(); unlock_wr_i = 0;
    chk("R10 open", unlock_rd_o, 8'h01);
    req_i = 4'b1000;
    bnd(); chk("R9 blocked 1", take_o, 0);
    bnd(); chk("R9 blocked 2", take_o, 0);
    unlock_wr_i = 1; unlock_data_i = 8'h00; step(); unlock_wr_i = 0;
    chk("R11 wrong value keeps open", unlock_rd_o, 8'h01);
    unlock_wr_i = 1; unlock_data_i = SIG; step(); unlock_wr_i = 0;
    for (int j = 0; j < 4; j++) begin
      chk("R10 open in window", unlock_rd_o, 8'h01);
      bnd();
      chk("R11 restarted window blocks", take_o, 0);
    end
    chk("R10 closed after window", unlock_rd_o, 0);
    bnd();
    chk("R9 taken after window", take_o, 1);
    chk("R9 vec", vec_o, 3);
    chk("R4 level no clear", flag_clr_o, 0);
    req_i = 0;
    fetch_len("R8 awake response", 4);

    finish_run();
  end
endmodule